// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Signature Lock

This block is a serial test access port for a programmable logic device. Four serial pins (test clock, mode select, data in, data out) step a sixteen-state controller that selects either a 4-bit instruction register or one of several data registers. The data registers are a one-bit bypass stage, a 32-bit identification word, a 16-bit user signature, a configuration readout word, and a boundary chain. The boundary chain holds one capture-only cell per input pin and one two-bit cell per macrocell. The macrocell cell covers both the output value and its enable. Each macrocell cell also has update stages, and these can take over the pad drivers.

Board test uses it to observe pins, drive pins from the chain, or isolate the part. A security lock input, held in the configuration store, blanks the configuration readout. The user signature stays readable while the lock is set. A programming-mode input floats every user output, whatever the active instruction.

Top module: `bscan_tap_top`

## Requirements
- R1: A synchronous active-high `rst` puts the controller in Test-Logic-Reset and loads the IDCODE instruction. The first data scan then returns the 32-bit identification word, whose LSB is 1. `tdo_oe` is low in that state.
- R2: Five consecutive clocks with `tms`=1 from any state reach Test-Logic-Reset and restore the IDCODE instruction.
- R3: The instruction register is 4 bits wide, shifts LSB first and captures 4'b0001. Opcodes: EXTEST 0000, SAMPLE/PRELOAD 0001, IDCODE 0010, HIGHZ 0011, USER-SIGNATURE 0100, CONFIG-READ 0101, BYPASS 1111. Any other opcode behaves as BYPASS. A new opcode takes effect on the clock that leaves Update-IR.
- R4: Under BYPASS the data path is one bit long and captures 0, so `tdo` repeats `tdi` one shift later.
- R5: The boundary chain is NPIN+2*NMC bits. Counted from the `tdo` end, bit i (i below NPIN) is pin cell i. Bit NPIN+2k is the output of macrocell k, and bit NPIN+2k+1 is its enable. Under SAMPLE/PRELOAD and EXTEST, Capture-DR loads `pin_in`, `core_out` and `core_oe` into these bits.
- R6: Under SAMPLE/PRELOAD or EXTEST, Update-DR copies the macrocell bits into the update stages. The update stages change at no other time. Outside EXTEST the pads follow `core_out` and `core_oe`.
- R7: Under EXTEST, `pad_out` and `pad_oe` take the update-stage values.
- R8: Under HIGHZ, every `pad_oe` bit is 0 and the bypass stage is the data path.
- R9: USER-SIGNATURE is a 16-bit register that captures `usig`, whatever the value of `sec_lock`.
- R10: CONFIG-READ captures `cfg_word` when `sec_lock` is 0. It captures all zeros when `sec_lock` is 1.
- R11: While `prog_mode` is 1, every `pad_oe` bit is 0, whatever the instruction.
- R12: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 only while the controller is in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous power-up reset, active high |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | High while data is being shifted out |
| pin_in | input | NPIN | Input pin values captured by the pin cells |
| core_out | input | NMC | Macrocell output values from the logic |
| core_oe | input | NMC | Macrocell output enables from the logic |
| usig | input | 16 | User signature value |
| cfg_word | input | CFG_W | Configuration readout word |
| sec_lock | input | 1 | Security lock bit from the configuration store |
| prog_mode | input | 1 | Programming mode, floats all user outputs |
| pad_out | output | NMC | Value sent to each pad driver |
| pad_oe | output | NMC | Enable sent to each pad driver |

## Verification
A wrong controller state shows up as a misframed scan: a wrong value on `tdo_oe` at the next falling edge, or a captured word shifted by one or more bits. A wrong instruction decode changes the data path length, so a bypass scan or an identification scan shows it within one scan. A fault in the update stages or the pad mux shows on `pad_out` and `pad_oe` at the first falling edge after Update-DR or Update-IR. A lock fault shows as nonzero data in a locked configuration readout.

// File: rtl/bscan_tap_pkg.sv
package bscan_tap_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
    localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0010;
    localparam logic [IR_W-1:0] OP_HIGHZ   = 4'b0011;
    localparam logic [IR_W-1:0] OP_USIG    = 4'b0100;
    localparam logic [IR_W-1:0] OP_CFGRD   = 4'b0101;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    typedef enum logic [2:0] {
        DR_BYPASS, DR_BOUND, DR_IDCODE, DR_USIG, DR_CFG
    } dr_sel_e;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } dr_ctl_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        unique case (s)
            ST_RESET:  return tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   return tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: return tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: return tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: return tms ? ST_SEL_DR : ST_IDLE;
            default:   return ST_RESET;
        endcase
    endfunction

    function automatic dr_sel_e decode_dr(logic [IR_W-1:0] op);
        unique case (op)
            OP_EXTEST, OP_SAMPLE: return DR_BOUND;
            OP_IDCODE:            return DR_IDCODE;
            OP_USIG:              return DR_USIG;
            OP_CFGRD:             return DR_CFG;
            default:              return DR_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/bscan_tap_fsm.sv
module bscan_tap_fsm
    import bscan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, tms);
    end

    AST_POWERUP_RESET: assert property (@(posedge tck) disable iff (rst)
        $past(rst) |-> state == ST_RESET);  // R1

    AST_TMS_HOLDS_RESET: assert property (@(posedge tck) disable iff (rst)
        (state == ST_RESET && tms) |=> state == ST_RESET);  // R2

    AST_SHIFT_STAYS: assert property (@(posedge tck) disable iff (rst)
        (state == ST_SH_DR && !tms) |=> state == ST_SH_DR);  // R12

endmodule

// File: rtl/bscan_tap_ir.sv
module bscan_tap_ir
    import bscan_tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_lsb
);

    logic [IR_W-1:0] ir_sr;

    always_ff @(posedge tck) begin
        if (rst) begin
            ir_sr <= IR_CAPTURE;
            ir_q  <= OP_IDCODE;
        end else begin
            if (state == ST_CAP_IR)      ir_sr <= IR_CAPTURE;
            else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            if (state == ST_RESET)       ir_q  <= OP_IDCODE;
            else if (state == ST_UPD_IR) ir_q  <= ir_sr;
        end
    end

    assign ir_lsb = ir_sr[0];

    AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (rst)
        state == ST_CAP_IR |=> ir_sr == IR_CAPTURE);  // R3

    AST_IR_STABLE: assert property (@(posedge tck) disable iff (rst)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir_q));  // R3

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_tap_pkg::*;
#(
    parameter int NPIN = 4,
    parameter int NMC  = 8
) (
    input  logic           tck,
    input  logic           rst,
    input  dr_ctl_t        ctl,
    input  logic           tdi,
    input  logic [NPIN-1:0] pin_in,
    input  logic [NMC-1:0] core_out,
    input  logic [NMC-1:0] core_oe,
    output logic           so,
    output logic [NMC-1:0] upd_out,
    output logic [NMC-1:0] upd_oe
);

    localparam int W = NPIN + 2 * NMC;

    logic [W-1:0] cap_v;
    logic [W-1:0] sr;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        assign cap_v[i] = pin_in[i];
    end

    for (genvar k = 0; k < NMC; k++) begin : g_mc
        localparam int BO = NPIN + 2 * k;
        logic uo_q, ue_q;
        assign cap_v[BO]     = core_out[k];
        assign cap_v[BO + 1] = core_oe[k];
        always_ff @(posedge tck) begin
            if (rst) begin
                uo_q <= 1'b0;
                ue_q <= 1'b0;
            end else if (ctl.update) begin
                uo_q <= sr[BO];
                ue_q <= sr[BO + 1];
            end
        end
        assign upd_out[k] = uo_q;
        assign upd_oe[k]  = ue_q;
    end

    always_ff @(posedge tck) begin
        if (rst)              sr <= '0;
        else if (ctl.capture) sr <= cap_v;
        else if (ctl.shift)   sr <= {tdi, sr[W-1:1]};
    end

    assign so = sr[0];

    AST_UPDATE_ONLY: assert property (@(posedge tck) disable iff (rst)
        !ctl.update |=> ($stable(upd_out) && $stable(upd_oe)));  // R6

    AST_CHAIN_CAPTURE: assert property (@(posedge tck) disable iff (rst)
        ctl.capture |=> sr[NPIN-1:0] == $past(pin_in));  // R5

endmodule

// File: rtl/bscan_tap_top.sv
module bscan_tap_top
    import bscan_tap_pkg::*;
#(
    parameter int          NPIN       = 4,
    parameter int          NMC        = 8,
    parameter int          CFG_W      = 8,
    parameter logic [31:0] IDCODE_VAL = 32'h1A5C_003F
) (
    input  logic             tck,
    input  logic             rst,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_oe,
    input  logic [NPIN-1:0]  pin_in,
    input  logic [NMC-1:0]   core_out,
    input  logic [NMC-1:0]   core_oe,
    input  logic [15:0]      usig,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             sec_lock,
    input  logic             prog_mode,
    output logic [NMC-1:0]   pad_out,
    output logic [NMC-1:0]   pad_oe
);

    localparam int USIG_W = 16;
    localparam int ID_W   = 32;

    tap_state_e      state;
    logic [IR_W-1:0] ir_q;
    logic            ir_lsb;
    dr_sel_e         dr_sel;
    dr_ctl_t         bs_ctl;
    logic            bs_so;
    logic [NMC-1:0]  upd_out, upd_oe;
    logic            cap_dr, sh_dr, upd_dr;

    logic              byp_q;
    logic [ID_W-1:0]   id_sr;
    logic [USIG_W-1:0] us_sr;
    logic [CFG_W-1:0]  cf_sr;
    logic              dr_lsb;

    bscan_tap_fsm i_fsm (
        .tck(tck), .rst(rst), .tms(tms), .state(state)
    );

    bscan_tap_ir i_ir (
        .tck(tck), .rst(rst), .state(state), .tdi(tdi),
        .ir_q(ir_q), .ir_lsb(ir_lsb)
    );

    assign dr_sel = decode_dr(ir_q);
    assign cap_dr = (state == ST_CAP_DR);
    assign sh_dr  = (state == ST_SH_DR);
    assign upd_dr = (state == ST_UPD_DR);

    assign bs_ctl.capture = cap_dr && (dr_sel == DR_BOUND);
    assign bs_ctl.shift   = sh_dr  && (dr_sel == DR_BOUND);
    assign bs_ctl.update  = upd_dr && (ir_q == OP_EXTEST || ir_q == OP_SAMPLE);

    bscan_chain #(.NPIN(NPIN), .NMC(NMC)) i_chain (
        .tck(tck), .rst(rst), .ctl(bs_ctl), .tdi(tdi),
        .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
        .so(bs_so), .upd_out(upd_out), .upd_oe(upd_oe)
    );

    always_ff @(posedge tck) begin
        if (rst) begin
            byp_q <= 1'b0;
            id_sr <= IDCODE_VAL;
            us_sr <= '0;
            cf_sr <= '0;
        end else begin
            if (dr_sel == DR_BYPASS) begin
                if (cap_dr)     byp_q <= 1'b0;
                else if (sh_dr) byp_q <= tdi;
            end
            if (dr_sel == DR_IDCODE) begin
                if (cap_dr)     id_sr <= IDCODE_VAL;
                else if (sh_dr) id_sr <= {tdi, id_sr[ID_W-1:1]};
            end
            if (dr_sel == DR_USIG) begin
                if (cap_dr)     us_sr <= usig;
                else if (sh_dr) us_sr <= {tdi, us_sr[USIG_W-1:1]};
            end
            if (dr_sel == DR_CFG) begin
                if (cap_dr)     cf_sr <= sec_lock ? '0 : cfg_word;
                else if (sh_dr) cf_sr <= {tdi, cf_sr[CFG_W-1:1]};
            end
        end
    end

    always_comb begin
        unique case (dr_sel)
            DR_BOUND:  dr_lsb = bs_so;
            DR_IDCODE: dr_lsb = id_sr[0];
            DR_USIG:   dr_lsb = us_sr[0];
            DR_CFG:    dr_lsb = cf_sr[0];
            default:   dr_lsb = byp_q;
        endcase
    end

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= (state == ST_SH_IR) ? ir_lsb : dr_lsb;
            tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
        end
    end

    always_comb begin
        pad_out = core_out;
        pad_oe  = core_oe;
        if (ir_q == OP_EXTEST) begin
            pad_out = upd_out;
            pad_oe  = upd_oe;
        end
        if (ir_q == OP_HIGHZ || prog_mode) pad_oe = '0;
    end

    AST_BYPASS_ZERO: assert property (@(posedge tck) disable iff (rst)
        (cap_dr && dr_sel == DR_BYPASS) |=> byp_q == 1'b0);  // R4

    AST_USIG_OPEN: assert property (@(posedge tck) disable iff (rst)
        (cap_dr && dr_sel == DR_USIG) |=> us_sr == $past(usig));  // R9

    AST_CFG_HIDDEN: assert property (@(posedge tck) disable iff (rst)
        (cap_dr && dr_sel == DR_CFG && sec_lock) |=> cf_sr == '0);  // R10

    AST_FLOAT_OUTPUTS: assert property (@(posedge tck) disable iff (rst)
        (prog_mode || ir_q == OP_HIGHZ) |-> $countones(pad_oe) == 0);  // R11

endmodule

// File: tb/test_bscan_tap_top.sv
module test_bscan_tap_top;

    localparam int NPIN  = 4;
    localparam int NMC   = 8;
    localparam int CFG_W = 8;
    localparam int W     = NPIN + 2 * NMC;
    localparam logic [31:0] IDV = 32'h1A5C_003F;

    localparam logic [3:0] C_EXTEST = 4'b0000;
    localparam logic [3:0] C_SAMPLE = 4'b0001;
    localparam logic [3:0] C_IDCODE = 4'b0010;
    localparam logic [3:0] C_HIGHZ  = 4'b0011;
    localparam logic [3:0] C_USIG   = 4'b0100;
    localparam logic [3:0] C_CFGRD  = 4'b0101;
    localparam logic [3:0] C_BYPASS = 4'b1111;

    logic tck = 1'b0;
    logic rst, tms, tdi;
    logic tdo, tdo_oe;
    logic [NPIN-1:0]  pin_in;
    logic [NMC-1:0]   core_out, core_oe;
    logic [15:0]      usig;
    logic [CFG_W-1:0] cfg_word;
    logic             sec_lock, prog_mode;
    logic [NMC-1:0]   pad_out, pad_oe;

    int errs   = 0;
    int checks = 0;
    bit done   = 0;

    always #2.5 tck = ~tck;

    bscan_tap_top #(.NPIN(NPIN), .NMC(NMC), .CFG_W(CFG_W), .IDCODE_VAL(IDV)) i_bscan_tap_top (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe), .usig(usig),
        .cfg_word(cfg_word), .sec_lock(sec_lock), .prog_mode(prog_mode),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one TCK period: sample tdo after the falling edge, then drive tms/tdi
    task automatic tbit(input logic m, input logic d, output logic so);
        @(negedge tck);
        #1;
        so  = tdo;
        tms = m;
        tdi = d;
    endtask

    task automatic settle();
        @(negedge tck);
        #1;
    endtask

    task automatic shift_ir(input logic [3:0] code, output logic [3:0] cap);
        logic s;
        tbit(1, 0, s); tbit(1, 0, s); tbit(0, 0, s); tbit(0, 0, s);
        for (int i = 0; i < 4; i++) begin
            tbit(i == 3, code[i], s);
            cap[i] = s;
        end
        tbit(1, 0, s); tbit(0, 0, s);
        settle();
    endtask

    task automatic shift_dr(input int n, input logic [63:0] din,
                            output logic [63:0] dout, output logic oe_ok);
        logic s;
        dout  = '0;
        oe_ok = 1'b1;
        tbit(1, 0, s); tbit(1'b0, 0, s); tbit(0, 0, s);
        for (int i = 0; i < n; i++) begin
            tbit(i == n - 1, din[i], s);
            dout[i] = s;
            if (tdo_oe !== 1'b1) oe_ok = 1'b0;
        end
        tbit(1, 0, s); tbit(0, 0, s);
        settle();
    endtask

    function automatic logic [63:0] exp_cap(logic [NPIN-1:0] p, logic [NMC-1:0] o, logic [NMC-1:0] e);
        logic [63:0] v = '0;
        for (int i = 0; i < NPIN; i++) v[i] = p[i];
        for (int k = 0; k < NMC; k++) begin
            v[NPIN + 2 * k]     = o[k];
            v[NPIN + 2 * k + 1] = e[k];
        end
        return v;
    endfunction

    function automatic logic [NMC-1:0] mc_bits(logic [63:0] v, int off);
        logic [NMC-1:0] r;
        for (int k = 0; k < NMC; k++) r[k] = v[NPIN + 2 * k + off];
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] dout, din, din2;
        logic [3:0]  icap;
        logic        ok, s;
        int unsigned seed_dummy;

        seed_dummy = $urandom(32'h0000_5EED);
        rst = 1; tms = 1; tdi = 0;
        pin_in = 4'hA; core_out = 8'h5C; core_oe = 8'hF0;
        usig = 16'hBEEF; cfg_word = 8'h3C; sec_lock = 0; prog_mode = 0;
        repeat (3) @(posedge tck);
        @(negedge tck); rst = 0;
        #1;

        // R1: reset state
        chk("R1 tdo_oe in reset", {63'd0, tdo_oe}, 64'd0);
        chk("R6 pads follow core after reset", {48'd0, pad_oe, pad_out}, {48'd0, core_oe, core_out});
        tbit(0, 0, s);
        shift_dr(32, 64'd0, dout, ok);
        chk("R1 idcode after reset", dout, {32'd0, IDV});
        chk("R12 tdo_oe high in shift", {63'd0, ok}, 64'd1);
        chk("R12 tdo_oe low in idle", {63'd0, tdo_oe}, 64'd0);

        // R3: instruction capture
        shift_ir(C_BYPASS, icap);
        chk("R3 ir capture", {60'd0, icap}, 64'h1);

        // R4: bypass delay
        din = 64'h0000_0000_0003_5A6B;
        shift_dr(20, din, dout, ok);
        chk("R4 bypass stream", dout[19:0], {din[18:0], 1'b0});

        // R12: tdo changes only at falling edge
        tbit(1, 0, s); tbit(0, 0, s); tbit(0, 1, s);
        tbit(0, 1, s);
        chk("R12 first bypass bit", {63'd0, s}, 64'd0);
        @(posedge tck); #1;
        chk("R12 tdo held across rising edge", {63'd0, tdo}, 64'd0);
        @(negedge tck); #1;
        chk("R12 tdo after falling edge", {63'd0, tdo}, 64'd1);
        tms = 1; tbit(1, 0, s); tbit(0, 0, s);
        settle();

        // R3: undefined opcode behaves as bypass
        shift_ir(4'b1010, icap);
        shift_dr(8, 64'h00A5, dout, ok);
        chk("R3 undefined opcode is bypass", dout[7:0], {8'h4A});

        // R2: tms reset from mid-scan
        tbit(1, 0, s); tbit(0, 0, s); tbit(0, 0, s);
        for (int i = 0; i < 5; i++) tbit(1, 0, s);
        tbit(0, 0, s);
        settle();
        shift_dr(32, 64'd0, dout, ok);
        chk("R2 tms reset restores idcode", dout, {32'd0, IDV});

        // R5 R6 R7: random boundary traffic
        for (int it = 0; it < 10; it++) begin
            pin_in   = NPIN'($urandom);
            core_out = NMC'($urandom);
            core_oe  = NMC'($urandom);
            shift_ir(C_SAMPLE, icap);
            din = {32'd0, $urandom} & ((64'd1 << W) - 1);
            shift_dr(W, din, dout, ok);
            chk("R5 sample capture", dout, exp_cap(pin_in, core_out, core_oe));
            chk("R6 pads follow core under sample", {48'd0, pad_oe, pad_out}, {48'd0, core_oe, core_out});
            shift_ir(C_EXTEST, icap);
            chk("R7 extest drives preload", {48'd0, pad_oe, pad_out},
                {48'd0, mc_bits(din, 1), mc_bits(din, 0)});
            din2 = {32'd0, $urandom} & ((64'd1 << W) - 1);
            shift_dr(W, din2, dout, ok);
            chk("R5 extest capture", dout, exp_cap(pin_in, core_out, core_oe));
            chk("R7 extest drives update", {48'd0, pad_oe, pad_out},
                {48'd0, mc_bits(din2, 1), mc_bits(din2, 0)});
        end

        // R11: programming mode floats outputs under extest with all enables set
        din = '0;
        for (int k = 0; k < NMC; k++) din[NPIN + 2 * k + 1] = 1'b1;
        shift_dr(W, din, dout, ok);
        chk("R7 all enables driven", {56'd0, pad_oe}, {56'd0, {NMC{1'b1}}});
        prog_mode = 1; #1;
        chk("R11 prog mode floats", {56'd0, pad_oe}, 64'd0);
        prog_mode = 0; #1;
        chk("R11 prog mode released", {56'd0, pad_oe}, {56'd0, {NMC{1'b1}}});

        // R8: highz
        core_oe = 8'hFF;
        shift_ir(C_HIGHZ, icap);
        chk("R8 highz enables", {56'd0, pad_oe}, 64'd0);
        chk("R8 highz value path", {56'd0, pad_out}, {56'd0, core_out});
        shift_dr(6, 64'h2D, dout, ok);
        chk("R8 highz selects bypass", dout[5:0], {6'h1A});

        // R6: IDCODE scan leaves update stages untouched
        shift_ir(C_IDCODE, icap);
        shift_dr(32, 64'hFFFF_FFFF, dout, ok);
        shift_ir(C_EXTEST, icap);
        chk("R6 update held outside boundary", {56'd0, pad_oe}, {56'd0, {NMC{1'b1}}});

        // R9: user signature regardless of lock
        for (int l = 0; l < 2; l++) begin
            sec_lock = l[0];
            usig = 16'($urandom);
            shift_ir(C_USIG, icap);
            shift_dr(16, 64'd0, dout, ok);
            chk("R9 user signature readable", dout, {48'd0, usig});
        end

        // R10: configuration readout gated by lock
        sec_lock = 0;
        cfg_word = 8'hC6;
        shift_ir(C_CFGRD, icap);
        shift_dr(CFG_W, 64'd0, dout, ok);
        chk("R10 config open", dout, {56'd0, cfg_word});
        sec_lock = 1;
        shift_dr(CFG_W, 64'd0, dout, ok);
        chk("R10 config locked", dout, 64'd0);

        // R1: synchronous reset from a non-reset instruction
        @(negedge tck); rst = 1;
        @(negedge tck); rst = 0;
        #1;
        chk("R1 reset drops tdo_oe", {63'd0, tdo_oe}, 64'd0);
        tbit(0, 0, s);
        shift_dr(32, 64'd0, dout, ok);
        chk("R1 idcode after second reset", dout, {32'd0, IDV});

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule